// File: doc/BRIEF.md
# Priority Fit-Check Transmit Queue

This block holds the event-triggered messages a node still has to send in the dynamic part of a bus cycle. Every waiting message is described by a priority, a length in minislots and an index into payload storage kept outside the block. All of the node's dynamic messages share this single queue.

When the bus sequencer reaches a transmit opportunity, it sends a select request together with the number of minislots left in the segment. The queue scans the entries that were waiting when the request arrived. It returns the most urgent entry whose length fits that budget and removes it. When two candidates have the same priority, the one that arrived first wins. An urgent message that is too long is passed over in favour of a shorter, less urgent one. If nothing fits, the queue reports not-found and keeps every entry, so the messages wait for a later cycle. The length that is returned tells the sequencer how many minislots the transmission will take.

Top module: `dyn_txq`

## Requirements
- R1: After reset, occupancy is 0, the overflow count is 0, enq_ready is 1, and sel_busy and sel_done are 0.
- R2: An enqueue is taken on a clock edge where enq_valid and enq_ready are both 1. Occupancy then rises by one, unless a removal happens on the same edge.
- R3: enq_ready is 0 exactly when occupancy equals DEPTH. Each edge with enq_valid at 1 and enq_ready at 0 raises ovf_count by one, and the count saturates at its maximum.
- R4: A select returns, with sel_found at 1, the fitting entry with the numerically lowest priority (0 is the most urgent). That entry is removed from the queue.
- R5: Among fitting entries of equal priority, the one enqueued earliest is returned.
- R6: An entry whose length exceeds the budget is never returned, even when it is more urgent than the entry that is returned.
- R7: When no entry fits, sel_found is 0, sel_prio, sel_len and sel_idx are 0, and occupancy is unchanged by the select.
- R8: sel_done is a one-cycle pulse. It comes N+1 cycles after the edge that accepts the request, where N is the occupancy at that edge, so never later than DEPTH+2 cycles.
- R9: An entry enqueued on the edge that accepts a select, or while a scan is running, is not a candidate for that select. It stays queued for later ones.
- R10: A select request is accepted only while sel_busy is 0. Requests made while busy are ignored.
- R11: The fit test is inclusive: an entry whose length equals the budget fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Queue has a free entry |
| enq_prio | input | PRIO_W | Priority of the new message, 0 most urgent |
| enq_len | input | LEN_W | Length of the new message in minislots |
| enq_idx | input | IDX_W | Payload index of the new message |
| sel_req | input | 1 | Select request, sampled while not busy |
| sel_budget | input | LEN_W | Minislots left in the dynamic segment |
| sel_busy | output | 1 | A select scan is in progress |
| sel_done | output | 1 | One-cycle pulse: select result valid |
| sel_found | output | 1 | A fitting entry was returned and removed |
| sel_prio | output | PRIO_W | Priority of the returned entry |
| sel_len | output | LEN_W | Length of the returned entry, minislots to occupy |
| sel_idx | output | IDX_W | Payload index of the returned entry |
| occupancy | output | $clog2(DEPTH+1) | Number of queued entries |
| ovf_count | output | CNT_W | Count of refused enqueue attempts |

## Verification
The assertions check on every cycle that a returned length never exceeds the budget latched with its request. They also check that the result pulse comes within DEPTH+2 cycles and lasts one cycle, that the overflow count moves only on refused attempts, and that occupancy at each result matches the enqueue and removal seen on that edge. The choice among candidates can only be shown by the bench's scenarios, which compare every output on every clock against a behavioural queue model. That choice covers priority order, arrival order between equal priorities, passing over long urgent entries, the inclusive fit and the exclusion of late arrivals.

// File: rtl/dyn_txq.sv
module dyn_txq #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 4,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  output logic                       enq_ready,
  input  logic [PRIO_W-1:0]          enq_prio,
  input  logic [LEN_W-1:0]           enq_len,
  input  logic [IDX_W-1:0]           enq_idx,
  input  logic                       sel_req,
  input  logic [LEN_W-1:0]           sel_budget,
  output logic                       sel_busy,
  output logic                       sel_done,
  output logic                       sel_found,
  output logic [PRIO_W-1:0]          sel_prio,
  output logic [LEN_W-1:0]           sel_len,
  output logic [IDX_W-1:0]           sel_idx,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic [CNT_W-1:0]           ovf_count
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = $clog2(DEPTH);

  // entries stay packed in arrival order: slot 0 is the oldest
  logic [PRIO_W-1:0] q_prio [DEPTH];
  logic [LEN_W-1:0]  q_len  [DEPTH];
  logic [IDX_W-1:0]  q_idx  [DEPTH];
  logic [PRIO_W-1:0] n_prio [DEPTH];
  logic [LEN_W-1:0]  n_len  [DEPTH];
  logic [IDX_W-1:0]  n_idx  [DEPTH];

  logic [CW-1:0]     count, ptr, scan_n, best_pos, wpos;
  logic [LEN_W-1:0]  budget;
  logic [PRIO_W-1:0] best_prio;
  logic              busy, best_found;

  wire enq_fire  = enq_valid && enq_ready;
  wire scan_end  = busy && (ptr == scan_n);
  wire remove    = scan_end && best_found;
  wire [PW-1:0] p_i = ptr[PW-1:0];
  wire fits      = (q_len[p_i] <= budget) && (!best_found || q_prio[p_i] < best_prio);

  assign enq_ready = count < CW'(DEPTH);
  assign sel_busy  = busy;
  assign occupancy = count;
  assign wpos      = remove ? count - 1'b1 : count;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_prio[i] = q_prio[i];
      n_len[i]  = q_len[i];
      n_idx[i]  = q_idx[i];
      if (remove && CW'(i) >= best_pos) begin
        if (i + 1 < DEPTH) begin
          n_prio[i] = q_prio[(i+1) % DEPTH];
          n_len[i]  = q_len[(i+1) % DEPTH];
          n_idx[i]  = q_idx[(i+1) % DEPTH];
        end else begin
          n_prio[i] = '0;
          n_len[i]  = '0;
          n_idx[i]  = '0;
        end
      end
    end
    if (enq_fire) begin
      n_prio[wpos[PW-1:0]] = enq_prio;
      n_len[wpos[PW-1:0]]  = enq_len;
      n_idx[wpos[PW-1:0]]  = enq_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_prio[i] <= '0;
        q_len[i]  <= '0;
        q_idx[i]  <= '0;
      end
      count      <= '0;
      ovf_count  <= '0;
      busy       <= 1'b0;
      ptr        <= '0;
      scan_n     <= '0;
      budget     <= '0;
      best_found <= 1'b0;
      best_prio  <= '0;
      best_pos   <= '0;
      sel_done   <= 1'b0;
      sel_found  <= 1'b0;
      sel_prio   <= '0;
      sel_len    <= '0;
      sel_idx    <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        q_prio[i] <= n_prio[i];
        q_len[i]  <= n_len[i];
        q_idx[i]  <= n_idx[i];
      end
      count <= count + CW'(enq_fire) - CW'(remove);
      if (enq_valid && !enq_ready && ovf_count != '1)
        ovf_count <= ovf_count + 1'b1;

      sel_done <= 1'b0;
      if (!busy) begin
        if (sel_req) begin
          busy       <= 1'b1;
          ptr        <= '0;
          scan_n     <= count;
          budget     <= sel_budget;
          best_found <= 1'b0;
        end
      end else if (scan_end) begin
        busy      <= 1'b0;
        sel_done  <= 1'b1;
        sel_found <= best_found;
        sel_prio  <= best_found ? q_prio[best_pos[PW-1:0]] : '0;
        sel_len   <= best_found ? q_len[best_pos[PW-1:0]]  : '0;
        sel_idx   <= best_found ? q_idx[best_pos[PW-1:0]]  : '0;
      end else begin
        ptr <= ptr + 1'b1;
        if (fits) begin
          best_found <= 1'b1;
          best_prio  <= q_prio[p_i];
          best_pos   <= ptr;
        end
      end
    end
  end
endmodule

// File: rtl/dyn_txq_chk.sv
module dyn_txq_chk #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 4,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enq_valid,
  input logic                       enq_ready,
  input logic [PRIO_W-1:0]          enq_prio,
  input logic [LEN_W-1:0]           enq_len,
  input logic [IDX_W-1:0]           enq_idx,
  input logic                       sel_req,
  input logic [LEN_W-1:0]           sel_budget,
  input logic                       sel_busy,
  input logic                       sel_done,
  input logic                       sel_found,
  input logic [PRIO_W-1:0]          sel_prio,
  input logic [LEN_W-1:0]           sel_len,
  input logic [IDX_W-1:0]           sel_idx,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic [CNT_W-1:0]           ovf_count
);
  logic [LEN_W-1:0] bud_q;
  int lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bud_q <= '0;
      lat   <= 0;
    end else begin
      if (sel_req && !sel_busy) bud_q <= sel_budget;
      lat <= sel_busy ? lat + 1 : 0;
    end
  end

  // R11 / R6: a returned length never exceeds its budget
  a_r6_fits_budget: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done && sel_found |-> sel_len <= bud_q);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lat <= DEPTH + 2);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> !sel_done);

  a_r3_ovf_inc: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && !enq_ready && ovf_count != '1 |=> ovf_count == $past(ovf_count) + 1'b1);

  a_r3_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_valid && !enq_ready) |=> $stable(ovf_count));

  a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);

  // R2 / R4 / R7: occupancy on a result edge reflects enqueue and removal
  a_r4_occ_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |-> int'(occupancy) == int'($past(occupancy))
      + ($past(enq_valid && enq_ready) ? 1 : 0) - (sel_found ? 1 : 0));

  a_r7_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done && !sel_found |-> sel_len == '0 && sel_prio == '0 && sel_idx == '0);
endmodule

bind dyn_txq dyn_txq_chk #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .LEN_W(LEN_W),
  .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dyn_txq.sv
`timescale 1ns/1ps
module sim_dyn_txq;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, sel_req = 1'b0;
  logic [3:0] enq_prio = '0;
  logic [7:0] enq_len = '0, enq_idx = '0, sel_budget = '0;
  logic enq_ready, sel_busy, sel_done, sel_found;
  logic [3:0] sel_prio;
  logic [7:0] sel_len, sel_idx;
  logic [CW-1:0] occupancy;
  logic [15:0] ovf_count;

  always #4 clk = ~clk;

  dyn_txq u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_tag = "R4";

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mp[$], ml[$], mi[$];
  int m_ovf, m_rem, m_n, m_bud;
  bit m_busy, e_done, e_found;
  int e_p, e_l, e_i;

  always @(posedge clk) begin
    int sz0, best;
    bit acc, do_req;
    if (!rst_n) begin
      mp.delete(); ml.delete(); mi.delete();
      m_ovf = 0; m_busy = 0; m_rem = 0; e_done = 0;
      e_found = 0; e_p = 0; e_l = 0; e_i = 0;
    end else begin
      sz0 = mp.size();
      acc = sz0 < DEPTH;
      do_req = sel_req && !m_busy;
      e_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          best = -1;
          for (int k = 0; k < m_n; k++)
            if (ml[k] <= m_bud && (best < 0 || mp[k] < mp[best])) best = k;
          e_done = 1;
          m_busy = 0;
          if (best >= 0) begin
            e_found = 1; e_p = mp[best]; e_l = ml[best]; e_i = mi[best];
            mp.delete(best); ml.delete(best); mi.delete(best);
          end else begin
            e_found = 0; e_p = 0; e_l = 0; e_i = 0;
          end
        end
      end
      if (enq_valid) begin
        if (acc) begin
          mp.push_back(int'(enq_prio)); ml.push_back(int'(enq_len)); mi.push_back(int'(enq_idx));
        end else if (m_ovf < 65535) m_ovf++;
      end
      if (do_req) begin
        m_busy = 1; m_n = sz0; m_rem = sz0 + 1; m_bud = int'(sel_budget);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", int'(occupancy), mp.size(), "occupancy");
      chk("R3", int'(enq_ready), (mp.size() < DEPTH) ? 1 : 0, "enq_ready");
      chk("R3", int'(ovf_count), m_ovf, "ovf_count");
      chk("R10", int'(sel_busy), int'(m_busy), "sel_busy");
      chk("R8", int'(sel_done), int'(e_done), "sel_done");
      if (e_done) begin
        chk(cur_tag, int'(sel_found), int'(e_found), "sel_found");
        chk(cur_tag, int'(sel_prio), e_p, "sel_prio");
        chk(cur_tag, int'(sel_len), e_l, "sel_len");
        chk(cur_tag, int'(sel_idx), e_i, "sel_idx");
      end
    end
  end

  task automatic enq(int p, int l, int i);
    @(negedge clk);
    enq_valid = 1; enq_prio = 4'(p); enq_len = 8'(l); enq_idx = 8'(i);
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!sel_done && n < 40) begin @(negedge clk); n++; end
    chk("R8", int'(sel_done), 1, "done seen");
  endtask

  task automatic sel(int b, string tag);
    @(negedge clk);
    cur_tag = tag; sel_req = 1; sel_budget = 8'(b);
    @(negedge clk);
    sel_req = 0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(occupancy), 0, "reset occupancy");
    chk("R1", int'(ovf_count), 0, "reset ovf");
    chk("R1", int'(enq_ready), 1, "reset enq_ready");
    chk("R1", int'(sel_busy), 0, "reset busy");
    chk("R1", int'(sel_done), 0, "reset done");

    // R4: most urgent fitting entry
    enq(5, 10, 1); enq(2, 20, 2); enq(7, 5, 3); enq(2, 30, 4);
    sel(255, "R4");
    // R5: equal priority leaves in arrival order
    enq(2, 8, 5);
    sel(255, "R5");
    sel(255, "R5");
    // R6 and R11: skip long urgent entry, inclusive fit
    enq(0, 50, 6);
    sel(10, "R6_R11");
    // R7: nothing fits
    sel(4, "R7");
    // R9 and R10: same-cycle enqueue, enqueue and request while busy
    @(negedge clk);
    cur_tag = "R9";
    sel_req = 1; sel_budget = 8'd5;
    enq_valid = 1; enq_prio = 4'd1; enq_len = 8'd3; enq_idx = 8'd7;
    @(negedge clk);
    sel_req = 1; sel_budget = 8'd255;
    enq_prio = 4'd1; enq_len = 8'd2; enq_idx = 8'd8;
    @(negedge clk);
    sel_req = 0; enq_valid = 0;
    wait_done();
    sel(255, "R9");
    sel(3, "R9");
    // R3: fill, refuse, then drain
    for (int k = 0; k < DEPTH + 3; k++) enq(k % 4, 3 + k, 20 + k);
    chk("R3", int'(enq_ready), 0, "full enq_ready");
    chk("R3", int'(ovf_count), 4, "ovf after refusals");
    for (int k = 0; k < DEPTH + 2; k++) sel(6, "R4");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule